// File: doc/BRIEF.md
# Tilt Angle Character Display Driver

This block presents an 8-bit tilt reading as whole degrees on one line of a character LCD that uses the common 8-bit parallel command set. The reading comes from an external converter as a plain parallel code and is taken to mean 0 to 255 degrees with no scaling. A slow step strobe is derived from the system clock. After reset a fixed power-up script of 11 steps configures the display. Then a 16-step pass writes the line `TILT:ddd.00 DEG ` again and again, where `ddd` is the zero-padded decimal value of the reading.

Every step lasts one strobe period, which is split into four equal quarters. RS and the data bus change at the start of a step. The enable line rises one quarter later and stays high for two quarters. The last quarter is hold time. The tilt code has no handshake. It is captured once, as the set-address step of each pass ends, so all three digits of a line come from the same sample. After the 16th character the sequencer goes back to the set-address step and does not repeat initialization.

Top module: `tilt_lcd_ctrl`

## Requirements
- R1: While reset is high and right after it, the enable line is low and the sequencer sits at its first step. The first enable pulse after reset carries command 0x38 with RS low.
- R2: Every step lasts CLK_DIV clock cycles. Enable is high for CLK_DIV/2 cycles. RS and data are steady for at least CLK_DIV/4 cycles before the enable rises, and they do not change while it is high.
- R3: The read/write line is always low (write).
- R4: The pulsed commands of initialization come in this order, all with RS low: 0x38, 0x38, 0x38, 0x38, 0x0C, 0x01, 0x06, 0x80. The three idle steps (after 0x01 and two steps before 0x80) raise no enable pulse.
- R5: Each pass writes 16 characters with RS high. Positions 0 to 15 are 'T','I','L','T',':', then three digits, then '.','0','0',' ','D','E','G',' ', each sent as its ASCII code.
- R6: Digit positions 5, 6 and 7 carry the hundreds, tens and ones of the captured code, each sent as 0x30 plus the digit. Examples: 7 gives 0x30 0x30 0x37, 37 gives 0x30 0x33 0x37, 113 gives 0x31 0x31 0x33.
- R7: After the 16th character, the next pulse is the set-address command 0x80 with RS low, and a new pass follows. No other initialization command appears again.
- R8: The tilt code is captured once per pass, as the set-address step ends. A change on the input during a pass does not affect the digits of that pass.
- R9: A synchronous reset in mid-operation drives enable low, clears the strobe divider and restarts the full initialization sequence from its first command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tilt_code | input | TILT_W | Unsigned tilt reading in degrees, sampled once per pass |
| lcd_rs | output | 1 | Register select: low for command, high for character data |
| lcd_rw | output | 1 | Read/write select, held at write |
| lcd_e | output | 1 | Enable strobe |
| lcd_db | output | 8 | Command or character byte |

## Verification
The bench builds the block with CLK_DIV = 8, so each quarter step is two clock cycles and one 17-step refresh pass takes about 136 cycles. This keeps tens of full passes, a mid-run reset and the exact pulse-width and setup counts well within the run. TILT_W stays at 8, so every code from 0 to 255 can be applied. That covers the all-zero and maximum readings, the digit carries at 9/10, 99/100 and 199/200, and random codes.

// File: rtl/tilt_lcd_pkg.sv
package tilt_lcd_pkg;

  localparam int INIT_STEPS  = 11;
  localparam int LINE_CHARS  = 16;
  localparam int TOTAL_STEPS = INIT_STEPS + LINE_CHARS;
  localparam int ADDR_STEP   = INIT_STEPS - 1;
  localparam int STEP_W      = $clog2(TOTAL_STEPS);

  typedef struct packed {
    logic       pulse;  // raise enable during this step
    logic       rs;     // register select
    logic [7:0] code;   // bus byte
  } lcd_op_t;

  // power-up script; index ADDR_STEP is the set-address step reused by refresh
  function automatic lcd_op_t init_op(input int idx);
    lcd_op_t op;
    op = '{pulse: 1'b0, rs: 1'b0, code: 8'h00};
    case (idx)
      0, 1, 2, 3: op = '{pulse: 1'b1, rs: 1'b0, code: 8'h38}; // 8-bit, 2 lines, 5x8
      4:          op = '{pulse: 1'b1, rs: 1'b0, code: 8'h0C}; // display on, no cursor
      5:          op = '{pulse: 1'b1, rs: 1'b0, code: 8'h01}; // clear
      7:          op = '{pulse: 1'b1, rs: 1'b0, code: 8'h06}; // increment, no shift
      10:         op = '{pulse: 1'b1, rs: 1'b0, code: 8'h80}; // address 0x00
      default:    op = '{pulse: 1'b0, rs: 1'b0, code: 8'h00}; // idle
    endcase
    return op;
  endfunction

  // template text of the line; digit positions filled by caller
  function automatic logic [7:0] line_char(input int pos, input logic [7:0] hund,
                                           input logic [7:0] tens, input logic [7:0] ones);
    logic [7:0] c;
    case (pos)
      0:       c = "T";
      1:       c = "I";
      2:       c = "L";
      3:       c = "T";
      4:       c = ":";
      5:       c = hund;
      6:       c = tens;
      7:       c = ones;
      8:       c = ".";
      9, 10:   c = "0";
      12:      c = "D";
      13:      c = "E";
      14:      c = "G";
      default: c = " ";
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tilt_lcd_strobe.sv
module tilt_lcd_strobe #(
  parameter int CLK_DIV = 125000
) (
  input  logic       clk,
  input  logic       rst,
  output logic       tick,
  output logic [1:0] quarter
);
  localparam int QTR = CLK_DIV / 4;
  localparam int CW  = (QTR > 1) ? $clog2(QTR) : 1;
  localparam logic [CW-1:0] QTR_LAST = CW'(QTR - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == QTR_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      quarter <= 2'd0;
    end else if (tick) begin
      cnt     <= '0;
      quarter <= quarter + 2'd1;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  a_r2_count_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= QTR_LAST);

  a_r2_quarter_advance: assert property (@(posedge clk) disable iff (rst)
    tick |=> (quarter == $past(quarter) + 2'd1));

  a_r9_divider_cleared: assert property (@(posedge clk)
    rst |=> (cnt == '0 && quarter == 2'd0));

endmodule

// File: rtl/tilt_bin2ascii.sv
module tilt_bin2ascii #(
  parameter int W = 8
) (
  input  logic [W-1:0] value,
  output logic [7:0]   hund,
  output logic [7:0]   tens,
  output logic [7:0]   ones
);
  int v;

  always_comb begin
    v    = int'(value);
    hund = 8'h30 + 8'((v / 100) % 10);
    tens = 8'h30 + 8'((v / 10) % 10);
    ones = 8'h30 + 8'(v % 10);
  end

  always_comb begin
    a_r6_digit_range: assert (hund >= 8'h30 && hund <= 8'h39 &&
                              tens >= 8'h30 && tens <= 8'h39 &&
                              ones >= 8'h30 && ones <= 8'h39);
  end

endmodule

// File: rtl/tilt_lcd_seq.sv
module tilt_lcd_seq
  import tilt_lcd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [1:0]   quarter,
  input  logic [W-1:0] tilt_code,
  input  logic [7:0]   hund,
  input  logic [7:0]   tens,
  input  logic [7:0]   ones,
  output logic [W-1:0] tilt_q,
  output logic         lcd_e,
  output logic         lcd_rs,
  output logic [7:0]   lcd_db
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(TOTAL_STEPS - 1);
  localparam logic [STEP_W-1:0] ADDR_IDX  = STEP_W'(ADDR_STEP);

  logic [STEP_W-1:0] step;
  logic              e_q;
  logic              adv;
  lcd_op_t           op;

  assign adv = tick && (quarter == 2'd3);

  always_comb begin
    if (int'(step) < INIT_STEPS) begin
      op = init_op(int'(step));
    end else begin
      op.pulse = 1'b1;
      op.rs    = 1'b1;
      op.code  = line_char(int'(step) - INIT_STEPS, hund, tens, ones);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step   <= '0;
      e_q    <= 1'b0;
      tilt_q <= '0;
    end else begin
      if (tick)
        e_q <= op.pulse && (quarter == 2'd0 || quarter == 2'd1);
      if (adv) begin
        if (step == ADDR_IDX)
          tilt_q <= tilt_code;
        step <= (step == LAST_STEP) ? ADDR_IDX : step + STEP_W'(1);
      end
    end
  end

  assign lcd_e  = e_q;
  assign lcd_rs = op.rs;
  assign lcd_db = op.code;

  a_r2_bus_steady_while_e: assert property (@(posedge clk) disable iff (rst)
    e_q |-> $stable(step));

  a_r4_idle_has_no_pulse: assert property (@(posedge clk) disable iff (rst)
    e_q |-> op.pulse);

  a_r7_wrap_to_address: assert property (@(posedge clk) disable iff (rst)
    (adv && step == LAST_STEP) |=> (step == ADDR_IDX));

  a_r8_sample_held_in_pass: assert property (@(posedge clk) disable iff (rst)
    (step > ADDR_IDX) |=> $stable(tilt_q));

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (step == '0 && !e_q));

endmodule

// File: rtl/tilt_lcd_ctrl.sv
module tilt_lcd_ctrl #(
  parameter int CLK_DIV = 125000,
  parameter int TILT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TILT_W-1:0] tilt_code,
  output logic              lcd_rs,
  output logic              lcd_rw,
  output logic              lcd_e,
  output logic [7:0]        lcd_db
);
  generate
    if (CLK_DIV < 8 || (CLK_DIV % 4) != 0) begin : g_bad_div
      $error("CLK_DIV must be a multiple of 4 and at least 8");
    end
  endgenerate

  logic              tick;
  logic [1:0]        quarter;
  logic [TILT_W-1:0] tilt_q;
  logic [7:0]        hund, tens, ones;

  tilt_lcd_strobe #(.CLK_DIV(CLK_DIV)) u_strobe (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .quarter (quarter)
  );

  tilt_bin2ascii #(.W(TILT_W)) u_digits (
    .value (tilt_q),
    .hund  (hund),
    .tens  (tens),
    .ones  (ones)
  );

  tilt_lcd_seq #(.W(TILT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .quarter   (quarter),
    .tilt_code (tilt_code),
    .hund      (hund),
    .tens      (tens),
    .ones      (ones),
    .tilt_q    (tilt_q),
    .lcd_e     (lcd_e),
    .lcd_rs    (lcd_rs),
    .lcd_db    (lcd_db)
  );

  assign lcd_rw = 1'b0;

endmodule

// File: tb/sim_tilt_lcd_ctrl.sv
`timescale 1ns/1ps
module sim_tilt_lcd_ctrl;
  localparam int CLK_DIV = 8;
  localparam int QTR     = CLK_DIV / 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] tilt_code = 8'd0;
  logic       lcd_rs, lcd_rw, lcd_e;
  logic [7:0] lcd_db;

  int checks = 0;
  int errs   = 0;

  always #10 clk = ~clk;

  tilt_lcd_ctrl #(.CLK_DIV(CLK_DIV), .TILT_W(8)) u0 (
    .clk(clk), .rst(rst), .tilt_code(tilt_code),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e), .lcd_db(lcd_db)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_char(input int k, input int v);
    case (k)
      0: return "T";  1: return "I";  2: return "L";  3: return "T";
      4: return ":";
      5: return 8'h30 + 8'(v / 100);
      6: return 8'h30 + 8'((v / 10) % 10);
      7: return 8'h30 + 8'(v % 10);
      8: return ".";  9: return "0";  10: return "0"; 11: return " ";
      12: return "D"; 13: return "E"; 14: return "G"; default: return " ";
    endcase
  endfunction

  function automatic logic [7:0] init_cmd(input int i);
    case (i)
      0, 1, 2, 3: return 8'h38;
      4: return 8'h0C;
      5: return 8'h01;
      6: return 8'h06;
      default: return 8'h80;
    endcase
  endfunction

  // pulse monitor, sampling on the falling clock edge
  logic [8:0] pulses [0:1023];
  int         pcnt = 0;
  int         cyc = 0, hi_len = 0, stab_len = 0, last_rise = -1;
  logic       pe = 1'b0, held = 1'b1;
  logic [8:0] prev_bus = '0, cap = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      pe = 1'b0; hi_len = 0; stab_len = 0; last_rise = -1;
    end else begin
      if ({lcd_rs, lcd_db} == prev_bus) stab_len++; else stab_len = 1;
      if (lcd_e && !pe) begin
        chk(stab_len > QTR, "R2", "setup cycles before enable", stab_len, QTR + 1);
        chk(lcd_rw == 1'b0, "R3", "rw at enable", lcd_rw, 0);
        if (last_rise >= 0)
          chk(((cyc - last_rise) % CLK_DIV) == 0, "R2", "step spacing",
              cyc - last_rise, CLK_DIV);
        last_rise = cyc;
        hi_len = 1; held = 1'b1; cap = {lcd_rs, lcd_db};
      end else if (lcd_e) begin
        hi_len++;
        if ({lcd_rs, lcd_db} != cap) held = 1'b0;
      end
      if (!lcd_e && pe) begin
        chk(hi_len == CLK_DIV / 2, "R2", "enable width", hi_len, CLK_DIV / 2);
        chk(held, "R2", "bus held while enable high", {lcd_rs, lcd_db}, cap);
        if (pcnt < 1024) pulses[pcnt] = cap;
        pcnt++;
      end
      pe = lcd_e;
    end
    prev_bus = {lcd_rs, lcd_db};
  end

  task automatic wait_pulses(input int n);
    while (pcnt < n) @(posedge clk);
  endtask

  task automatic check_init(input int base, input string req);
    for (int i = 0; i < 8; i++) begin
      chk(pulses[base + i] == {1'b0, init_cmd(i)}, req, $sformatf("init cmd %0d", i),
          pulses[base + i], {1'b0, init_cmd(i)});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  localparam int NPASS = 22;
  int vals [0:NPASS-1];

  initial begin
    int seed_out;
    seed_out = $urandom(32'd4711);
    vals[0] = 7;   vals[1] = 37;  vals[2] = 113; vals[3] = 0;
    vals[4] = 255; vals[5] = 100; vals[6] = 99;  vals[7] = 200;
    vals[8] = 9;   vals[9] = 10;  vals[10] = 199;
    for (int i = 11; i < NPASS; i++) vals[i] = int'($urandom % 256);

    tilt_code = 8'(vals[0]);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(lcd_e == 1'b0, "R1", "enable during reset", lcd_e, 0);
    chk(lcd_rw == 1'b0, "R3", "rw during reset", lcd_rw, 0);
    @(posedge clk);
    rst <= 1'b0;

    wait_pulses(8);
    chk(pulses[0] == {1'b0, 8'h38}, "R1", "first pulse after reset", pulses[0], {1'b0, 8'h38});
    check_init(0, "R4");

    for (int p = 0; p < NPASS; p++) begin
      int base;
      base = 7 + 17 * p;
      wait_pulses(base + 4);
      tilt_code <= ~8'(vals[p]);             // R8: mid-pass change must not show
      if (p + 1 < NPASS) begin
        wait_pulses(base + 16);
        tilt_code <= 8'(vals[p + 1]);
      end
      wait_pulses(base + 17);
      chk(pulses[base] == {1'b0, 8'h80}, "R7", $sformatf("address cmd pass %0d", p),
          pulses[base], {1'b0, 8'h80});
      for (int k = 0; k < 16; k++) begin
        logic [8:0] e9;
        e9 = {1'b1, exp_char(k, vals[p])};
        chk(pulses[base + 1 + k] == e9, (k >= 5 && k <= 7) ? "R6/R8" : "R5",
            $sformatf("pass %0d char %0d", p, k), pulses[base + 1 + k], e9);
      end
    end

    // R9: reset in mid-operation
    @(posedge clk);
    while (lcd_e) @(posedge clk);
    repeat (3) @(posedge clk);
    rst <= 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(lcd_e == 1'b0, "R9", "enable during mid-run reset", lcd_e, 0);
    @(posedge clk);
    rst <= 1'b0;
    begin
      int start;
      start = pcnt;
      wait_pulses(start + 8);
      check_init(start, "R9");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

endmodule